// File: doc/BRIEF.md
# Snoop Intervention Response Agent

This block connects one processor to a shared, snooping, split-read system bus. It watches coherent transactions on the bus. These are ordinary reads, exclusive reads, invalidates and writes. A read is not acted on when it is observed. The agent records the read, and only when the bus opens the response phase for it does the agent send an intervention to its processor. It holds a busy signal that stretches the response phase until the processor returns the state of the line.

When the processor answers, the agent produces a one-cycle reply. The reply carries a valid flag, a shared flag and a takeover flag. The values depend on the kind of read and on the returned line state. A requester that sees no agent report shared may take the line as exclusive. On a takeover, the agent drives the dirty line onto the bus for the requester and, in the same cycle, onto a memory writeback port. It also tells the processor how to downgrade its copy. A bus invalidate counts as complete the moment it appears, and the agent forwards it to the processor on the next cycle. Bus writes are ignored.

Top module: `snoop_agent`

## Requirements
- R1: A read (bus_cmd 1) or exclusive read (bus_cmd 2) seen while no read is outstanding produces no intervention by itself. The cycle after bus_rsp_start is sampled for that read, ivr_valid rises with ivr_addr equal to the read address and ivr_excl set only for bus_cmd 2. ivr_valid then stays high until cpu_ack.
- R2: agent_busy rises together with ivr_valid and falls in the same cycle that rsp_valid is 1. agent_busy stays high for as many cycles as the processor delays cpu_ack.
- R3: For an ordinary read, rsp_shared is 1 when cpu_line_st is 1 (shared) or 2 (clean exclusive), and 0 when it is 0 (invalid). rsp_takeover is 0 in these three cases. For clean exclusive, upd_valid is raised with upd_op 0 (change to shared). For shared and invalid, no update is sent.
- R4: For an ordinary read that finds cpu_line_st 3 (dirty exclusive), rsp_shared and rsp_takeover are both 1, sup_valid carries cpu_line_data, and upd_valid is raised with upd_op 0 (change to shared).
- R5: Whenever sup_valid is 1, wb_valid is 1 in the same cycle, with wb_data equal to sup_data and wb_addr equal to the intervention address.
- R6: For an exclusive read, rsp_shared is always 0. If the line is dirty exclusive, rsp_takeover is 1, the data is supplied and upd_op is 1 (invalidate). If the line is shared or clean exclusive, only upd_valid with upd_op 1 is raised. If the line is invalid, nothing but rsp_valid is raised.
- R7: A write (bus_cmd 4) on the bus changes no output.
- R8: An invalidate (bus_cmd 3), in any agent state, raises cpu_inv_valid for one cycle on the next cycle, with cpu_inv_addr equal to the bus address.
- R9: rsp_valid is a single-cycle pulse, one for each read that completes, in the cycle after cpu_ack is sampled.
- R10: Reads seen on the bus while a read is already outstanding (recorded or under intervention) are ignored. bus_rsp_start and cpu_ack outside their expected phase have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Bus transaction present this cycle |
| bus_cmd | input | 3 | 1 read, 2 exclusive read, 3 invalidate, 4 write |
| bus_addr | input | AW | Line address of the bus transaction |
| bus_rsp_start | input | 1 | Response phase of the outstanding read begins |
| cpu_ack | input | 1 | Processor answers the intervention |
| cpu_line_st | input | 2 | Line state returned: 0 invalid, 1 shared, 2 clean exclusive, 3 dirty exclusive |
| cpu_line_data | input | DW | Line data returned with the answer |
| ivr_valid | output | 1 | Intervention request to the processor |
| ivr_addr | output | AW | Intervention line address |
| ivr_excl | output | 1 | Intervention is for an exclusive read |
| agent_busy | output | 1 | Extends the bus read response |
| rsp_valid | output | 1 | Reply flags valid |
| rsp_shared | output | 1 | Shared indication |
| rsp_takeover | output | 1 | Takeover indication |
| sup_valid | output | 1 | Line data supplied to requester |
| sup_data | output | DW | Supplied line data |
| wb_valid | output | 1 | Memory writeback strobe |
| wb_addr | output | AW | Writeback address |
| wb_data | output | DW | Writeback data |
| upd_valid | output | 1 | State change command to processor for the intervention line |
| upd_op | output | 1 | 0 change to shared, 1 invalidate |
| cpu_inv_valid | output | 1 | Forwarded bus invalidate |
| cpu_inv_addr | output | AW | Forwarded invalidate address |

## Verification
The bench builds the agent with a 12-bit address and 16-bit data, which is narrow enough that distinct addresses and data patterns are easy to tell apart in every reply. It runs all eight pairings of read kind and line state, with processor delays from zero to several cycles, so the busy stretch is exercised at its shortest and at longer lengths. It also places invalidates, writes and extra reads inside the recorded and waiting phases to reach the ignore and forwarding paths.

// File: rtl/snp_pkg.sv
package snp_pkg;
  localparam logic [2:0] CMD_READ  = 3'd1;
  localparam logic [2:0] CMD_READX = 3'd2;
  localparam logic [2:0] CMD_INV   = 3'd3;
  localparam logic [2:0] CMD_WRITE = 3'd4;

  localparam logic [1:0] LS_INV   = 2'd0;
  localparam logic [1:0] LS_SHR   = 2'd1;
  localparam logic [1:0] LS_CLEAN = 2'd2;
  localparam logic [1:0] LS_DIRTY = 2'd3;

  localparam logic OP_TO_SHARED  = 1'b0;
  localparam logic OP_INVALIDATE = 1'b1;

  typedef enum logic [1:0] {TR_IDLE, TR_PEND, TR_WAIT} trk_state_t;

  typedef struct packed {
    logic shared;
    logic takeover;
    logic upd;
    logic upd_op;
  } reply_t;
endpackage

// File: rtl/snp_tracker.sv
module snp_tracker import snp_pkg::*; #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_valid,
  input  logic [2:0]    bus_cmd,
  input  logic [AW-1:0] bus_addr,
  input  logic          rsp_start,
  input  logic          cpu_ack,
  output logic          ivr_valid,
  output logic [AW-1:0] ivr_addr,
  output logic          ivr_excl,
  output logic          busy,
  output logic          done
);
  trk_state_t st;
  logic       is_read;

  assign is_read = bus_valid && (bus_cmd == CMD_READ || bus_cmd == CMD_READX);
  assign done    = (st == TR_WAIT) && cpu_ack;

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= TR_IDLE;
      ivr_valid <= 1'b0;
      ivr_addr  <= '0;
      ivr_excl  <= 1'b0;
      busy      <= 1'b0;
    end else begin
      case (st)
        TR_IDLE: if (is_read) begin
          st       <= TR_PEND;
          ivr_addr <= bus_addr;
          ivr_excl <= (bus_cmd == CMD_READX);
        end
        TR_PEND: if (rsp_start) begin
          st        <= TR_WAIT;
          ivr_valid <= 1'b1;
          busy      <= 1'b1;
        end
        TR_WAIT: if (cpu_ack) begin
          st        <= TR_IDLE;
          ivr_valid <= 1'b0;
          busy      <= 1'b0;
        end
        default: st <= TR_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/snp_decode.sv
module snp_decode import snp_pkg::*; (
  input  logic       excl,
  input  logic [1:0] line_st,
  output reply_t     rep
);
  always_comb begin
    rep = '0;
    if (excl) begin
      case (line_st)
        LS_DIRTY: begin
          rep.takeover = 1'b1;
          rep.upd      = 1'b1;
          rep.upd_op   = OP_INVALIDATE;
        end
        LS_SHR, LS_CLEAN: begin
          rep.upd    = 1'b1;
          rep.upd_op = OP_INVALIDATE;
        end
        default: rep = '0;
      endcase
    end else begin
      case (line_st)
        LS_DIRTY: begin
          rep.shared   = 1'b1;
          rep.takeover = 1'b1;
          rep.upd      = 1'b1;
          rep.upd_op   = OP_TO_SHARED;
        end
        LS_CLEAN: begin
          rep.shared = 1'b1;
          rep.upd    = 1'b1;
          rep.upd_op = OP_TO_SHARED;
        end
        LS_SHR:  rep.shared = 1'b1;
        default: rep = '0;
      endcase
    end
  end
endmodule

// File: rtl/snp_out_stage.sv
module snp_out_stage import snp_pkg::*; #(
  parameter int AW = 32,
  parameter int DW = 64
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          done,
  input  reply_t        rep,
  input  logic [DW-1:0] line_data,
  input  logic [AW-1:0] line_addr,
  input  logic          bus_valid,
  input  logic [2:0]    bus_cmd,
  input  logic [AW-1:0] bus_addr,
  output logic          rsp_valid,
  output logic          rsp_shared,
  output logic          rsp_takeover,
  output logic          sup_valid,
  output logic [DW-1:0] sup_data,
  output logic          wb_valid,
  output logic [AW-1:0] wb_addr,
  output logic [DW-1:0] wb_data,
  output logic          upd_valid,
  output logic          upd_op,
  output logic          inv_valid,
  output logic [AW-1:0] inv_addr
);
  logic take;
  assign take = done && rep.takeover;

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid    <= 1'b0;
      rsp_shared   <= 1'b0;
      rsp_takeover <= 1'b0;
      sup_valid    <= 1'b0;
      wb_valid     <= 1'b0;
      upd_valid    <= 1'b0;
      upd_op       <= 1'b0;
      inv_valid    <= 1'b0;
      sup_data     <= '0;
      wb_data      <= '0;
      wb_addr      <= '0;
      inv_addr     <= '0;
    end else begin
      rsp_valid    <= done;
      rsp_shared   <= done && rep.shared;
      rsp_takeover <= take;
      sup_valid    <= take;
      wb_valid     <= take;
      upd_valid    <= done && rep.upd;
      upd_op       <= done && rep.upd_op;
      if (take) begin
        sup_data <= line_data;
        wb_data  <= line_data;
        wb_addr  <= line_addr;
      end
      inv_valid <= bus_valid && (bus_cmd == CMD_INV);
      if (bus_valid && bus_cmd == CMD_INV) inv_addr <= bus_addr;
    end
  end
endmodule

// File: rtl/snoop_agent.sv
module snoop_agent import snp_pkg::*; #(
  parameter int AW = 32,
  parameter int DW = 64
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_valid,
  input  logic [2:0]    bus_cmd,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_rsp_start,
  input  logic          cpu_ack,
  input  logic [1:0]    cpu_line_st,
  input  logic [DW-1:0] cpu_line_data,
  output logic          ivr_valid,
  output logic [AW-1:0] ivr_addr,
  output logic          ivr_excl,
  output logic          agent_busy,
  output logic          rsp_valid,
  output logic          rsp_shared,
  output logic          rsp_takeover,
  output logic          sup_valid,
  output logic [DW-1:0] sup_data,
  output logic          wb_valid,
  output logic [AW-1:0] wb_addr,
  output logic [DW-1:0] wb_data,
  output logic          upd_valid,
  output logic          upd_op,
  output logic          cpu_inv_valid,
  output logic [AW-1:0] cpu_inv_addr
);
  logic   done;
  reply_t rep;

  snp_tracker #(.AW(AW)) u_trk (
    .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_cmd(bus_cmd),
    .bus_addr(bus_addr), .rsp_start(bus_rsp_start), .cpu_ack(cpu_ack),
    .ivr_valid(ivr_valid), .ivr_addr(ivr_addr), .ivr_excl(ivr_excl),
    .busy(agent_busy), .done(done)
  );

  snp_decode u_dec (
    .excl(ivr_excl), .line_st(cpu_line_st), .rep(rep)
  );

  snp_out_stage #(.AW(AW), .DW(DW)) u_out (
    .clk(clk), .rst(rst), .done(done), .rep(rep),
    .line_data(cpu_line_data), .line_addr(ivr_addr),
    .bus_valid(bus_valid), .bus_cmd(bus_cmd), .bus_addr(bus_addr),
    .rsp_valid(rsp_valid), .rsp_shared(rsp_shared), .rsp_takeover(rsp_takeover),
    .sup_valid(sup_valid), .sup_data(sup_data),
    .wb_valid(wb_valid), .wb_addr(wb_addr), .wb_data(wb_data),
    .upd_valid(upd_valid), .upd_op(upd_op),
    .inv_valid(cpu_inv_valid), .inv_addr(cpu_inv_addr)
  );
endmodule

// File: rtl/snp_agent_chk.sv
module snp_agent_chk #(
  parameter int AW = 32,
  parameter int DW = 64
) (
  input logic          clk,
  input logic          rst,
  input logic          bus_valid,
  input logic [2:0]    bus_cmd,
  input logic [AW-1:0] bus_addr,
  input logic          bus_rsp_start,
  input logic          cpu_ack,
  input logic [1:0]    cpu_line_st,
  input logic [DW-1:0] cpu_line_data,
  input logic          ivr_valid,
  input logic [AW-1:0] ivr_addr,
  input logic          ivr_excl,
  input logic          agent_busy,
  input logic          rsp_valid,
  input logic          rsp_shared,
  input logic          rsp_takeover,
  input logic          sup_valid,
  input logic [DW-1:0] sup_data,
  input logic          wb_valid,
  input logic [AW-1:0] wb_addr,
  input logic [DW-1:0] wb_data,
  input logic          upd_valid,
  input logic          upd_op,
  input logic          cpu_inv_valid,
  input logic [AW-1:0] cpu_inv_addr
);
  // R1
  no_early_ivr_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && (bus_cmd == 3'd1 || bus_cmd == 3'd2) && !agent_busy && !bus_rsp_start)
    |=> !ivr_valid);
  // R2
  busy_end_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(agent_busy) |-> rsp_valid);
  // R5
  twin_path_chk: assert property (@(posedge clk) disable iff (rst)
    sup_valid |-> (wb_valid && wb_data == sup_data && wb_addr == ivr_addr));
  // R6
  excl_no_shared_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && ivr_excl) |-> !rsp_shared);
  // R4
  take_shared_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_takeover && !ivr_excl) |-> (rsp_shared && sup_valid && upd_valid && !upd_op));
  // R8
  inv_fwd_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && bus_cmd == 3'd3) |=> (cpu_inv_valid && cpu_inv_addr == $past(bus_addr)));
  // R7
  write_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && bus_cmd == 3'd4) |=> !cpu_inv_valid);
  // R9
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);
endmodule

bind snoop_agent snp_agent_chk #(.AW(AW), .DW(DW)) u_chk (.*);

// File: tb/sim_snoop_agent.sv
`timescale 1ns/1ps
module sim_snoop_agent;
  localparam int AW = 12;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_valid = 1'b0;
  logic [2:0] bus_cmd = '0;
  logic [AW-1:0] bus_addr = '0;
  logic bus_rsp_start = 1'b0;
  logic cpu_ack = 1'b0;
  logic [1:0] cpu_line_st = '0;
  logic [DW-1:0] cpu_line_data = '0;
  logic ivr_valid, ivr_excl, agent_busy, rsp_valid, rsp_shared, rsp_takeover;
  logic sup_valid, wb_valid, upd_valid, upd_op, cpu_inv_valid;
  logic [AW-1:0] ivr_addr, wb_addr, cpu_inv_addr;
  logic [DW-1:0] sup_data, wb_data;

  always #4 clk = ~clk;

  snoop_agent #(.AW(AW), .DW(DW)) u0 (.*);

  int n_cmp = 0, n_bad = 0;
  bit finished = 1'b0;

  // behavioural reference
  int m_phase = 0;
  logic e_ivr = 0, e_excl = 0, e_busy = 0, e_rsp = 0, e_sh = 0, e_tk = 0;
  logic e_upd = 0, e_op = 0, e_inv = 0;
  logic [AW-1:0] e_addr = 0, e_inv_addr = 0;
  logic [DW-1:0] e_data = 0;

  always @(posedge clk) begin
    if (rst) begin
      m_phase = 0; e_ivr = 0; e_excl = 0; e_busy = 0; e_rsp = 0; e_sh = 0;
      e_tk = 0; e_upd = 0; e_op = 0; e_inv = 0; e_addr = 0;
    end else begin
      e_rsp = 0; e_sh = 0; e_tk = 0; e_upd = 0; e_op = 0;
      e_inv = bus_valid && bus_cmd == 3;
      if (e_inv) e_inv_addr = bus_addr;
      if (m_phase == 0) begin
        if (bus_valid && (bus_cmd == 1 || bus_cmd == 2)) begin
          m_phase = 1; e_addr = bus_addr; e_excl = (bus_cmd == 2);
        end
      end else if (m_phase == 1) begin
        if (bus_rsp_start) begin m_phase = 2; e_ivr = 1; e_busy = 1; end
      end else if (cpu_ack) begin
        m_phase = 0; e_ivr = 0; e_busy = 0; e_rsp = 1;
        if (!e_excl) begin
          e_sh = (cpu_line_st != 0);
          e_tk = (cpu_line_st == 3);
          e_upd = (cpu_line_st == 3 || cpu_line_st == 2);
        end else begin
          e_tk = (cpu_line_st == 3);
          e_upd = (cpu_line_st != 0);
          e_op = (cpu_line_st != 0);
        end
        if (e_tk) e_data = cpu_line_data;
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s at %0t: actual %h expected %h", tag, $time, act, exp);
    end
  endtask

  always @(negedge clk) if (!finished) begin
    chk("R1 ivr_valid", ivr_valid, e_ivr);
    chk("R1 ivr_excl", ivr_excl, e_excl);
    chk("R1 ivr_addr", ivr_addr, e_addr);
    chk("R2 agent_busy", agent_busy, e_busy);
    chk("R9 rsp_valid", rsp_valid, e_rsp);
    chk("R3 R6 rsp_shared", rsp_shared, e_sh);
    chk("R4 R6 rsp_takeover", rsp_takeover, e_tk);
    chk("R5 sup_valid", sup_valid, e_tk);
    chk("R5 wb_valid", wb_valid, e_tk);
    if (e_tk) begin
      chk("R4 sup_data", sup_data, e_data);
      chk("R5 wb_data", wb_data, e_data);
      chk("R5 wb_addr", wb_addr, e_addr);
    end
    chk("R3 R4 R6 upd_valid", upd_valid, e_upd);
    if (e_upd) chk("R6 upd_op", upd_op, e_op);
    chk("R7 R8 cpu_inv_valid", cpu_inv_valid, e_inv);
    if (e_inv) chk("R8 cpu_inv_addr", cpu_inv_addr, e_inv_addr);
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      bus_valid = 0; bus_rsp_start = 0; cpu_ack = 0;
    end
  endtask

  task automatic bus_op(input logic [2:0] c, input logic [AW-1:0] a);
    @(negedge clk);
    bus_valid = 1; bus_cmd = c; bus_addr = a; bus_rsp_start = 0; cpu_ack = 0;
  endtask

  task automatic read_seq(input logic [2:0] c, input logic [AW-1:0] a,
                          input logic [1:0] st, input logic [DW-1:0] d, input int dly);
    bus_op(c, a);
    idle(2);
    @(negedge clk); bus_rsp_start = 1;
    idle(dly + 1);
    @(negedge clk); cpu_ack = 1; cpu_line_st = st; cpu_line_data = d;
    idle(3);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    idle(3);
    @(negedge clk); rst = 0;
    idle(2);
    // R3 R4 ordinary reads in all states; R6 exclusive reads in all states
    for (int k = 0; k < 8; k++) begin
      read_seq((k < 4) ? 3'd1 : 3'd2, AW'(12'h100 + k * 12'h11),
               2'(k % 4), DW'(16'hA500 + k * 16'h0123), k % 4);
    end
    // R10 extra read while recorded, rsp_start and ack out of phase
    @(negedge clk); cpu_ack = 1; cpu_line_st = 3;
    @(negedge clk); cpu_ack = 0; bus_rsp_start = 1;
    idle(1);
    bus_op(3'd1, 12'h2A0);
    bus_op(3'd2, 12'h3B0);
    idle(1);
    @(negedge clk); bus_rsp_start = 1;
    // R10 read and R8 invalidate during wait, R7 write
    bus_op(3'd1, 12'h4C0);
    bus_op(3'd3, 12'h5D5);
    bus_op(3'd4, 12'h6E6);
    idle(2);
    @(negedge clk); cpu_ack = 1; cpu_line_st = 3; cpu_line_data = 16'hBEEF;
    idle(3);
    // R7 write and R8 invalidate while idle
    bus_op(3'd4, 12'h777);
    idle(1);
    bus_op(3'd3, 12'h888);
    bus_op(3'd3, 12'h999);
    idle(2);
    // back-to-back long delay dirty reads
    read_seq(3'd1, 12'hABC, 2'd3, 16'h1357, 6);
    read_seq(3'd2, 12'hDEF, 2'd3, 16'h2468, 0);
    idle(4);
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule